// File: doc/BRIEF.md
# Byte-Lane Lowercase-to-Uppercase Stream Converter

This block sits in a buffer-processing datapath and rewrites text held in 128-bit words. Each word is split into sixteen byte lanes. Every lane goes through the same logic in the same cycle, and no lane takes a conditional path. Each lane computes two candidate bytes: the byte as it came in, and the absolute difference between that byte and 0x20. The lane then builds a byte-wide mask from the exclusive OR of two unsigned greater-than tests, one against 0x60 and one against 0x7A. A per-bit select uses the mask to choose between the two candidates. As a result, bytes 0x61 to 0x7A lose 0x20 and every other byte passes through unchanged.

A job starts with a command that gives a start address and a byte length. The block clears the low four bits of the start address, so the buffer must already be 16-byte aligned and padded to a whole number of words. Padding bytes are converted like any other byte. Input words are accepted over a valid/ready handshake. Each converted word leaves one cycle later through a registered output, tagged with the word address it belongs to. That address starts at the aligned start and grows by 16 for each word. The job ends when the next address would exceed start plus length. The word that ends the job is flagged as the final word.

Top module: `caseconv_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `busy` and `in_ready` are 0.
- R2: Any output byte whose input byte is in 0x61..0x7A equals the input byte minus 0x20. Each of the 16 lanes (byte i = bits 8i+7..8i) is handled independently of the others.
- R3: Any input byte outside 0x61..0x7A appears unchanged at the output. This covers 0x60, 0x7B, uppercase letters, digits, punctuation, spaces and 0x80..0xFF, because the comparisons are unsigned.
- R4: The input word 0x48656c6c6f2054686572652120202020 produces 0x48454c4c4f2054484552452120202020.
- R5: A word accepted at a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after that same edge.
- R6: `in_ready` equals `busy` AND `out_ready`. While `out_valid` is high and `out_ready` is low, the output word, address and final flag stay stable.
- R7: A command loads the start address with its low 4 bits cleared. The first word of a job carries that address, and each later word carries the previous address plus 16.
- R8: Words are accepted until a word's address plus 16 exceeds the aligned start plus the length. That word has `out_last` = 1, and `busy` falls on the same edge. A length of 0 therefore takes one word, and a length of 32 takes three.
- R9: A command presented while `busy` is high is ignored. The running job keeps its addresses and its end point.
- R10: While `busy` is low, `in_valid` is not accepted and produces no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Starts a job when the block is idle |
| cmd_addr | input | 32 | Start byte address of the buffer |
| cmd_len | input | 16 | Buffer length in bytes |
| busy | output | 1 | A job is active |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_data | input | 128 | Sixteen input bytes |
| out_valid | output | 1 | Converted word present |
| out_ready | input | 1 | Downstream accepts the converted word |
| out_data | output | 128 | Sixteen converted bytes |
| out_addr | output | 32 | Word address of the converted word |
| out_last | output | 1 | Final word of the job |

## Verification
The hardest case to reach from the ports is a new word arriving while the previous converted word is still held by downstream backpressure. Reaching it requires `out_ready` to drop in exactly the cycles where a word is waiting. The stimulus toggles `out_ready` pseudo-randomly while words arrive with random gaps, so stalls land on every phase of the handshake. It also sends a set of sixteen words that together hold all 256 byte values, which exercises every lane against every boundary byte. Separate jobs with lengths 0 and 32 confirm where the word counter stops.

// File: rtl/caseconv_pkg.sv
package caseconv_pkg;

    localparam int LANES       = 16;
    localparam int LANE_W      = 8;
    localparam int WORD_W      = LANES * LANE_W;
    localparam int WORD_BYTES  = LANES;
    localparam int ALIGN_BITS  = $clog2(WORD_BYTES);
    localparam int ADDR_W      = 32;
    localparam int LEN_W       = 16;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;

    // distance between a lowercase letter and its uppercase form
    localparam lane_t CASE_GAP    = 8'h20;
    // one below the first lowercase letter
    localparam lane_t LOWER_FLOOR = 8'h60;
    // the last lowercase letter
    localparam lane_t LOWER_CEIL  = 8'h7A;

    typedef struct packed {
        word_t data;
        addr_t addr;
        logic  last;
    } beat_t;

    function automatic lane_t abs_diff(input lane_t a, input lane_t b);
        return (a > b) ? lane_t'(a - b) : lane_t'(b - a);
    endfunction

    function automatic lane_t fill_lane(input logic bit_v);
        return bit_v ? '1 : '0;
    endfunction

endpackage

// File: rtl/caseconv_lane.sv
module caseconv_lane
    import caseconv_pkg::*;
(
    input  lane_t byte_in,
    output lane_t byte_out
);
    lane_t above_floor;
    lane_t above_ceil;
    lane_t pick_mask;
    lane_t shifted;

    always_comb begin
        above_floor = fill_lane(byte_in > LOWER_FLOOR);
        above_ceil  = fill_lane(byte_in > LOWER_CEIL);
        pick_mask   = above_floor ^ above_ceil;
        shifted     = abs_diff(byte_in, CASE_GAP);
        byte_out    = (byte_in & ~pick_mask) | (shifted & pick_mask);
    end
endmodule

// File: rtl/caseconv_word.sv
module caseconv_word
    import caseconv_pkg::*;
(
    input  word_t word_in,
    output word_t word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        caseconv_lane u_lane (
            .byte_in  (word_in[g*LANE_W +: LANE_W]),
            .byte_out (word_out[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/caseconv_seq.sv
module caseconv_seq
    import caseconv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid,
    input  addr_t cmd_addr,
    input  len_t  cmd_len,
    input  logic  step,
    output logic  busy,
    output addr_t cur_addr,
    output logic  is_last
);
    localparam addr_t ALIGN_MASK = addr_t'(WORD_BYTES - 1);
    localparam addr_t STRIDE     = addr_t'(WORD_BYTES);

    addr_t end_addr;
    addr_t next_addr;
    addr_t start_aligned;

    always_comb begin
        start_aligned = cmd_addr & ~ALIGN_MASK;
        next_addr     = cur_addr + STRIDE;
        is_last       = next_addr > end_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur_addr <= '0;
            end_addr <= '0;
        end else if (!busy) begin
            if (cmd_valid) begin
                busy     <= 1'b1;
                cur_addr <= start_aligned;
                end_addr <= start_aligned + addr_t'(cmd_len);
            end
        end else if (step) begin
            cur_addr <= next_addr;
            if (is_last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/caseconv_top.sv
module caseconv_top
    import caseconv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [LEN_W-1:0]     cmd_len,
    output logic                 busy,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_last
);
    logic  accept;
    logic  seq_busy;
    addr_t seq_addr;
    logic  seq_last;
    word_t converted;
    beat_t held;
    logic  held_valid;

    caseconv_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .step      (accept),
        .busy      (seq_busy),
        .cur_addr  (seq_addr),
        .is_last   (seq_last)
    );

    caseconv_word u_word (
        .word_in  (in_data),
        .word_out (converted)
    );

    always_comb begin
        in_ready = seq_busy & out_ready;
        accept   = in_valid & in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held       <= '0;
        end else if (accept) begin
            held_valid <= 1'b1;
            held.data  <= converted;
            held.addr  <= seq_addr;
            held.last  <= seq_last;
        end else if (out_ready) begin
            held_valid <= 1'b0;
        end
    end

    assign busy      = seq_busy;
    assign out_valid = held_valid;
    assign out_data  = held.data;
    assign out_addr  = held.addr;
    assign out_last  = held.last;
endmodule

// File: rtl/caseconv_chk.sv
module caseconv_chk
    import caseconv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_last
);
    assert_accept_emits_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_addr) && $stable(out_last)));

    assert_addr_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr[ALIGN_BITS-1:0] == '0));

    assert_last_ends_job_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_last == !busy));

    assert_idle_no_word_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !$rose(out_valid));
endmodule

bind caseconv_top caseconv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_addr  (out_addr),
    .out_last  (out_last)
);

// File: tb/tb_caseconv_top.sv
module tb_caseconv_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic [31:0]  cmd_addr = '0;
    logic [15:0]  cmd_len = '0;
    logic         busy;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_data;
    logic [31:0]  out_addr;
    logic         out_last;

    int  checks = 0;
    int  errors = 0;
    int  n_out  = 0;
    bit  finished = 1'b0;
    bit  bp_on = 1'b0;

    always #4 clk = ~clk;

    caseconv_top dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .busy(busy), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_addr(out_addr), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] got,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [127:0] ref_conv(input logic [127:0] w);
        logic [127:0] r = w;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] b = w[8*i +: 8];
            if (b >= 8'h61 && b <= 8'h7A) r[8*i +: 8] = b - 8'h20;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        #1;
        out_ready = bp_on ? 1'($urandom % 2) : 1'b1;
    end

    // behavioural reference, compared every cycle
    bit           m_busy = 0, m_ov = 0, m_ol = 0;
    logic [127:0] m_od = '0;
    logic [31:0]  m_oa = '0, m_addr = '0, m_end = '0;

    always @(negedge clk) begin
        bit b0;
        bit acc;
        chk(busy == m_busy, "R8 busy", 128'(busy), 128'(m_busy));
        chk(in_ready == (m_busy && out_ready), "R6 in_ready", 128'(in_ready),
            128'(m_busy && out_ready));
        chk(out_valid == m_ov, "R5 out_valid", 128'(out_valid), 128'(m_ov));
        if (m_ov && out_valid) begin
            chk(out_data == m_od, "R2 R3 data", out_data, m_od);
            chk(out_addr == m_oa, "R7 addr", 128'(out_addr), 128'(m_oa));
            chk(out_last == m_ol, "R8 last", 128'(out_last), 128'(m_ol));
        end
        if (out_valid && out_ready) n_out++;
        b0 = m_busy;
        if (rst) begin
            m_busy = 0; m_ov = 0; m_ol = 0; m_od = '0; m_oa = '0;
            m_addr = '0; m_end = '0;
        end else begin
            acc = in_valid && m_busy && out_ready;
            if (acc) begin
                m_od = ref_conv(in_data);
                m_oa = m_addr;
                m_ol = (m_addr + 32'd16) > m_end;
                m_ov = 1;
                m_addr = m_addr + 32'd16;
                if (m_ol) m_busy = 0;
            end else if (out_ready) begin
                m_ov = 0;
            end
            if (cmd_valid && !b0) begin
                m_addr = {cmd_addr[31:4], 4'h0};
                m_end  = {cmd_addr[31:4], 4'h0} + 32'(cmd_len);
                m_busy = 1;
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic start_job(input logic [31:0] a, input logic [15:0] l);
        cmd_valid = 1'b1; cmd_addr = a; cmd_len = l;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic send_word(input logic [127:0] d);
        bit a;
        in_valid = 1'b1; in_data = d;
        for (int g = 0; g < 200; g++) begin
            @(negedge clk); a = in_ready;
            tick();
            if (a) break;
        end
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] rnd_word();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n0;
        repeat (3) tick();
        @(negedge clk);
        chk(!out_valid && !busy && !in_ready, "R1 reset", 128'({out_valid, busy, in_ready}), 128'(0));
        tick();
        rst = 1'b0;
        tick();
        @(negedge clk);
        chk(!out_valid && !busy, "R1 after reset", 128'({out_valid, busy}), 128'(0));

        // R10: input offered while idle
        in_valid = 1'b1; in_data = rnd_word();
        repeat (3) tick();
        @(negedge clk);
        chk(!out_valid && n_out == 0, "R10 idle", 128'(n_out), 128'(0));
        tick();
        in_valid = 1'b0;

        // R4 and R7: example text, misaligned start address
        start_job(32'h0000_1003, 16'd48);
        send_word(128'h48656c6c6f2054686572652120202020);
        @(negedge clk);
        chk(out_data == 128'h48454c4c4f2054484552452120202020, "R4 example",
            out_data, 128'h48454c4c4f2054484552452120202020);
        chk(out_addr == 32'h1000, "R7 aligned start", 128'(out_addr), 128'h1000);
        for (int i = 0; i < 3; i++) send_word(rnd_word());
        @(negedge clk);
        chk(out_last && out_addr == 32'h1030 && !busy, "R8 end of job",
            128'(out_addr), 128'h1030);
        tick();

        // R2 R3: all 256 byte values across 16 words
        start_job(32'h0000_2000, 16'd240);
        for (int k = 0; k < 16; k++) begin
            logic [127:0] w;
            for (int l = 0; l < 16; l++) w[8*l +: 8] = 8'(k*16 + l);
            send_word(w);
        end
        tick();

        // R6: random backpressure with random input gaps
        bp_on = 1'b1;
        start_job(32'h0000_3000, 16'd160);
        for (int i = 0; i < 11; i++) begin
            repeat ($urandom % 3) tick();
            send_word(rnd_word());
        end
        repeat (4) tick();
        bp_on = 1'b0;
        repeat (4) tick();

        // R8: length 0 takes one word
        start_job(32'h0000_4000, 16'd0);
        n0 = n_out;
        in_valid = 1'b1; in_data = rnd_word();
        repeat (4) tick();
        in_valid = 1'b0;
        tick();
        chk(n_out - n0 == 1, "R8 len0 words", 128'(n_out - n0), 128'(1));

        // R8: length 32 takes three words
        start_job(32'h0000_4100, 16'd32);
        n0 = n_out;
        in_valid = 1'b1; in_data = rnd_word();
        repeat (6) tick();
        in_valid = 1'b0;
        tick();
        chk(n_out - n0 == 3, "R8 len32 words", 128'(n_out - n0), 128'(3));

        // R9: command during a running job is ignored
        start_job(32'h0000_5000, 16'd32);
        send_word(rnd_word());
        start_job(32'h0000_9000, 16'd0);
        send_word(rnd_word());
        send_word(rnd_word());
        @(negedge clk);
        chk(out_addr == 32'h5020 && out_last, "R9 ignored cmd", 128'(out_addr), 128'h5020);
        tick();

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule